// File: doc/BRIEF.md
# Coupled Performance Ratio Counters

This block keeps two 64-bit activity counters that software samples to estimate how much work a core really delivered. The reference counter advances at a fixed rate whenever the core is active. The delivered counter advances on every clock in which the core is active and its clock is not gated off by throttling. During throttling the reference count keeps growing and the delivered count stalls, so their ratio falls in step with the lost performance.

The two counters are coupled at the top of their range. When either registered count equals all ones, both counters return to zero on the next clock. Software can reach both counters through a small indexed register port: it can read either count, or load either count with a new value.

Top module: `perf_ratio_counters`

## Requirements
- R1: After reset both counters hold zero and a read of either returns zero.
- R2: The reference counter (index 0xE7) rises by one on each clock where `tick_i` and `active_i` are both high, whatever the value of `gate_i`.
- R3: The delivered counter (index 0xE8) rises by one on each clock where `active_i` and `gate_i` are both high, with or without `tick_i`.
- R4: Neither counter changes on a clock where `active_i` is low.
- R5: When the registered value of either counter is all ones, both counters are zero after the next clock. A counter that reaches all ones shows that value for exactly one cycle.
- R6: A write with `wr_en_i` high loads the counter at `idx_i` (0xE7 or 0xE8) with `wdata_i`. In that cycle the write wins over both the increment and the overflow clear. The other counter follows its normal rules.
- R7: A read with `rd_en_i` high returns on `rdata_o` the counter value held at the start of that cycle, one clock later. `rvalid_o` is high for that one cycle only. A write to the same index in the same cycle does not change the value returned.
- R8: Indices other than 0xE7 and 0xE8 return zero on read and ignore writes. Both counters are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Fixed-rate tick, one clock wide |
| active_i | input | 1 | Core is active |
| gate_i | input | 1 | Throttle gate open (core clock running) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| idx_i | input | 8 | Register index |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |

## Verification
The bench loads counts just below all ones and lets them tick up, then reads them back. This checks that all ones is visible for exactly one cycle before both counters clear. A design that wraps each counter on its own, or clears them a cycle early, returns the wrong value. It also writes a counter in the very cycle an overflow clear is pending. This catches a clear that overrides the write. Throttled and inactive cycles confirm that only the delivered count stalls under the gate. Reads of unused indices and writes to them confirm that nothing is decoded there.

// File: rtl/perf_ratio_counters.sv
module perf_ratio_counters #(
  parameter int W = 64,
  parameter int IW = 8,
  parameter logic [IW-1:0] REF_IDX = 8'hE7,
  parameter logic [IW-1:0] ACT_IDX = 8'hE8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          active_i,
  input  logic          gate_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          rvalid_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] ref_q, act_q;
  logic         wrap, ref_inc, act_inc, ref_wr, act_wr;

  assign wrap    = (ref_q == MAXV) || (act_q == MAXV);
  assign ref_inc = active_i && tick_i;
  assign act_inc = active_i && gate_i;
  assign ref_wr  = wr_en_i && (idx_i == REF_IDX);
  assign act_wr  = wr_en_i && (idx_i == ACT_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      act_q <= '0;
    end else begin
      if (ref_wr)       ref_q <= wdata_i;
      else if (wrap)    ref_q <= '0;
      else if (ref_inc) ref_q <= ref_q + 1'b1;
      if (act_wr)       act_q <= wdata_i;
      else if (wrap)    act_q <= '0;
      else if (act_inc) act_q <= act_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i)
        rdata_o <= (idx_i == REF_IDX) ? ref_q :
                   (idx_i == ACT_IDX) ? act_q : '0;
    end
  end
endmodule

module perf_ratio_counters_chk #(
  parameter int W = 64,
  parameter int IW = 8,
  parameter logic [IW-1:0] REF_IDX = 8'hE7,
  parameter logic [IW-1:0] ACT_IDX = 8'hE8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          active_i,
  input logic          gate_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [IW-1:0] idx_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  rdata_o,
  input logic          rvalid_o,
  input logic [W-1:0]  ref_q,
  input logic [W-1:0]  act_q
);
  localparam logic [W-1:0] MAXV = '1;
  logic at_top;
  assign at_top = (ref_q == MAXV) || (act_q == MAXV);

  p_ref_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !at_top && tick_i && active_i) |=> ref_q == $past(ref_q) + 1'b1);

  p_act_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !at_top && gate_i && active_i) |=> act_q == $past(act_q) + 1'b1);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !at_top && !active_i) |=> ($stable(ref_q) && $stable(act_q)));

  p_joint_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && at_top) |=> (ref_q == '0 && act_q == '0));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_i == REF_IDX) |=> ref_q == $past(wdata_i));

  p_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rvalid_o);

  p_rvalid_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rvalid_o);

  p_read_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && idx_i == ACT_IDX) |=> rdata_o == $past(act_q));

  p_unused_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && idx_i != REF_IDX && idx_i != ACT_IDX) |=> rdata_o == '0);
endmodule

bind perf_ratio_counters perf_ratio_counters_chk #(
  .W(W), .IW(IW), .REF_IDX(REF_IDX), .ACT_IDX(ACT_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .active_i(active_i),
  .gate_i(gate_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .idx_i(idx_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
  .ref_q(ref_q), .act_q(act_q)
);

// File: tb/tb_perf_ratio_counters.sv
module tb_perf_ratio_counters;
  localparam logic [63:0] MAXV = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [7:0] RI = 8'hE7;
  localparam logic [7:0] AI = 8'hE8;
  localparam int NV = 26;
  // {tag[3:0], tick, active, gate, wr, rd, idx[7:0], wdata[63:0]}
  localparam logic [80:0] VEC [NV] = '{
    {4'd1, 5'b00001, RI, 64'd0},          // R1 reset value
    {4'd1, 5'b00001, AI, 64'd0},          // R1
    {4'd2, 5'b11100, RI, 64'd0},
    {4'd2, 5'b11101, RI, 64'd0},          // R2
    {4'd3, 5'b01101, AI, 64'd0},          // R3 no tick
    {4'd3, 5'b11001, AI, 64'd0},          // R3 throttled
    {4'd2, 5'b11001, RI, 64'd0},          // R2 throttled still counts
    {4'd4, 5'b10101, RI, 64'd0},          // R4 inactive
    {4'd6, 5'b11110, RI, MAXV - 64'd1},   // R6 write beats increment
    {4'd5, 5'b11101, RI, 64'd0},          // R5 reaches top
    {4'd5, 5'b00001, RI, 64'd0},          // R5 top shown once
    {4'd5, 5'b00001, AI, 64'd0},          // R5 partner cleared
    {4'd6, 5'b00010, AI, MAXV},
    {4'd6, 5'b00010, RI, 64'd5},          // R6 write beats clear
    {4'd6, 5'b00001, RI, 64'd0},
    {4'd5, 5'b00001, AI, 64'd0},
    {4'd8, 5'b00010, 8'h10, 64'd123},     // R8 write ignored
    {4'd8, 5'b00001, 8'h10, 64'd0},       // R8 reads zero
    {4'd8, 5'b00001, RI, 64'd0},          // R8 counters untouched
    {4'd6, 5'b01110, AI, MAXV - 64'd1},
    {4'd5, 5'b01101, AI, 64'd0},
    {4'd5, 5'b00001, AI, 64'd0},
    {4'd5, 5'b00001, RI, 64'd0},          // R5 ref cleared by act top
    {4'd7, 5'b00011, RI, MAXV},           // R7 read sees old value
    {4'd6, 5'b00010, RI, 64'd7},          // R6 write during pending clear
    {4'd6, 5'b00001, RI, 64'd0}
  };

  logic clk = 0, rst_n = 0;
  logic tick_i = 0, active_i = 0, gate_i = 0, wr_en_i = 0, rd_en_i = 0;
  logic [7:0] idx_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic rvalid_o;
  int total = 0, bad = 0;
  logic [63:0] mref = '0, mact = '0;

  always #2.5 clk = ~clk;

  perf_ratio_counters dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .active_i(active_i),
    .gate_i(gate_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .idx_i(idx_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic string tname(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(input logic [80:0] v);
    logic [63:0] exp_rd;
    logic ovf;
    logic rd;
    {tick_i, active_i, gate_i, wr_en_i, rd_en_i} = v[76:72];
    idx_i = v[71:64];
    wdata_i = v[63:0];
    rd = v[72];
    exp_rd = (v[71:64] == RI) ? mref : (v[71:64] == AI) ? mact : 64'd0;
    ovf = (mref == MAXV) || (mact == MAXV);
    if (wr_en_i && idx_i == RI) mref = wdata_i;
    else if (ovf) mref = '0;
    else if (tick_i && active_i) mref = mref + 1;
    if (wr_en_i && idx_i == AI) mact = wdata_i;
    else if (ovf) mact = '0;
    else if (active_i && gate_i) mact = mact + 1;
    @(posedge clk);
    @(negedge clk);
    check("R7", {63'd0, rvalid_o}, {63'd0, rd});
    if (rd) check(tname(int'(v[80:77])), rdata_o, exp_rd);
  endtask

  initial begin
    #20000;
    bad++;
    total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {63'd0, rvalid_o}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) step(VEC[i]);
    // ratio under throttling: ref advances, delivered stalls (R2, R3)
    for (int i = 0; i < 10; i++) step({4'd3, 5'b11000, RI, 64'd0});
    step({4'd2, 5'b00001, RI, 64'd0});
    step({4'd3, 5'b00001, AI, 64'd0});
    // reset in mid-run clears both (R1)
    step({4'd6, 5'b00010, AI, 64'd99});
    rst_n = 0;
    mref = '0; mact = '0;
    @(negedge clk);
    rst_n = 1;
    step({4'd1, 5'b00001, RI, 64'd0});
    step({4'd1, 5'b00001, AI, 64'd0});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule